// File: doc/BRIEF.md
# Two-Stage UART Bit-Rate Generator

This block turns a fast reference clock into the two timing strobes a UART needs. The first stage is a 16-bit clock divisor that emits a one-cycle sample strobe every `clk_div` reference cycles. Receivers use it as their oversampling enable. The second stage counts sample strobes and emits a bit strobe after every `bit_div + 1` of them. That strobe sets the transmitter's bit period.

The resulting bit rate is `f_ref / (clk_div * (bit_div + 1))`. Software sets the two divisors through a plain write port that carries a byte offset and a 16-bit data word. A write to either divisor restarts both counters, so the first period after a rate change is a whole period. A clock divisor of zero stops both strobes. A bit divisor below four is raised to four.

Top module: `ubd_baud_gen`

## Requirements
- R1: After reset both strobes are low, the clock divisor holds 0 (no strobes), and the bit divisor holds 15. With only the clock divisor written afterwards, the bit period is `clk_div * 16` cycles.
- R2: With a clock divisor D ≥ 1, the sample strobe repeats every D cycles.
- R3: With an effective bit divisor N, the bit strobe repeats every `D * (N + 1)` cycles. It coincides with every (N+1)-th sample strobe and is never high on two consecutive cycles.
- R4: A bit divisor value of 0 to 3 behaves exactly as 4.
- R5: While the clock divisor is 0, neither strobe is ever asserted.
- R6: A write to either divisor restarts both counters. Take the first cycle after the write edge as cycle 1. The first sample strobe then falls in cycle D and the first bit strobe falls in cycle `D * (N + 1)`.
- R7: The clock divisor is loaded from `wr_data_i[15:0]` at byte offset 0x18. The bit divisor is loaded from `wr_data_i[7:0]` at byte offset 0x34, and bits 15:8 are ignored. A write to any other offset changes neither the rate nor the phase of the strobes.
- R8: When D ≥ 2, the sample strobe is one cycle wide. When D = 1, it is high continuously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Byte offset of the write |
| wr_data_i | input | 16 | Write data |
| sample_tick_o | output | 1 | Oversampling enable strobe |
| baud_tick_o | output | 1 | Bit-period strobe |

## Verification
The divisor registers and counters update on the write edge. Both strobes are decoded combinationally from those registers, so no extra pipeline stage sits between them and the outputs. The bench drives each write at a falling edge and counts observations at later falling edges, with the first observation just after the write edge as cycle 1. A sample strobe is expected in cycle D and a bit strobe in cycle D·(N+1). Every following spacing is measured from one observed strobe to the next at those same falling edges.

// File: rtl/ubd_pkg.sv
package ubd_pkg;
  localparam int unsigned ADDR_W      = 8;
  localparam int unsigned DATA_W      = 16;
  localparam int unsigned CLK_DIV_W   = 16;
  localparam int unsigned BIT_DIV_W   = 8;
  localparam logic [ADDR_W-1:0] OFS_CLK_DIV = 8'h18;
  localparam logic [ADDR_W-1:0] OFS_BIT_DIV = 8'h34;
  localparam int unsigned BIT_DIV_MIN = 4;
  localparam int unsigned BIT_DIV_RST = 15;
endpackage

// File: rtl/ubd_regs.sv
module ubd_regs
  import ubd_pkg::*;
#(
  parameter int unsigned CDW = CLK_DIV_W,
  parameter int unsigned BDW = BIT_DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [CDW-1:0]    clk_div_o,
  output logic [BDW-1:0]    bit_div_o,
  output logic              restart_o
);
  logic hit_clk, hit_bit;

  assign hit_clk   = wr_en_i && (wr_addr_i == OFS_CLK_DIV);
  assign hit_bit   = wr_en_i && (wr_addr_i == OFS_BIT_DIV);
  assign restart_o = hit_clk || hit_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_div_o <= '0;
      bit_div_o <= BDW'(BIT_DIV_RST);
    end else begin
      if (hit_clk) clk_div_o <= wr_data_i[CDW-1:0];
      if (hit_bit) bit_div_o <= wr_data_i[BDW-1:0];
    end
  end
endmodule

// File: rtl/ubd_prescale.sv
module ubd_prescale #(
  parameter int unsigned CDW = 16
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic [CDW-1:0] div_i,
  output logic           tick_o
);
  logic [CDW-1:0] cnt_q;
  logic           active, wrap;

  assign active = (div_i != '0);
  assign wrap   = (cnt_q == div_i - CDW'(1));
  assign tick_o = active && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (restart_i || !active || wrap) cnt_q <= '0;
    else                                 cnt_q <= cnt_q + CDW'(1);
  end
endmodule

// File: rtl/ubd_bitcnt.sv
module ubd_bitcnt #(
  parameter int unsigned BDW     = 8,
  parameter int unsigned MIN_DIV = 4
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           restart_i,
  input  logic           sample_i,
  input  logic [BDW-1:0] div_i,
  output logic           tick_o
);
  logic [BDW-1:0] cnt_q, lim;
  logic           wrap;

  // values below the floor act as the floor
  assign lim    = (div_i < BDW'(MIN_DIV)) ? BDW'(MIN_DIV) : div_i;
  assign wrap   = (cnt_q == lim);
  assign tick_o = sample_i && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (restart_i)         cnt_q <= '0;
    else if (sample_i && wrap)  cnt_q <= '0;
    else if (sample_i)          cnt_q <= cnt_q + BDW'(1);
  end
endmodule

// File: rtl/ubd_baud_gen.sv
module ubd_baud_gen
  import ubd_pkg::*;
#(
  parameter int unsigned CDW = CLK_DIV_W,
  parameter int unsigned BDW = BIT_DIV_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              sample_tick_o,
  output logic              baud_tick_o
);
  logic [CDW-1:0] clk_div;
  logic [BDW-1:0] bit_div;
  logic           restart;

  ubd_regs #(.CDW(CDW), .BDW(BDW)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .clk_div_o(clk_div), .bit_div_o(bit_div), .restart_o(restart)
  );

  ubd_prescale #(.CDW(CDW)) u_pre (
    .clk_i, .rst_ni, .restart_i(restart), .div_i(clk_div),
    .tick_o(sample_tick_o)
  );

  ubd_bitcnt #(.BDW(BDW), .MIN_DIV(BIT_DIV_MIN)) u_bit (
    .clk_i, .rst_ni, .restart_i(restart), .sample_i(sample_tick_o),
    .div_i(bit_div), .tick_o(baud_tick_o)
  );
endmodule

// File: rtl/ubd_baud_gen_chk.sv
module ubd_baud_gen_chk
  import ubd_pkg::*;
#(
  parameter int unsigned CDW = CLK_DIV_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [CDW-1:0]    clk_div,
  input logic              sample_tick_o,
  input logic              baud_tick_o
);
  logic div_wr;
  assign div_wr = wr_en_i && (wr_addr_i == OFS_CLK_DIV || wr_addr_i == OFS_BIT_DIV);

  AST_BAUD_ON_SAMPLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |-> sample_tick_o); // R3
  AST_BAUD_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    baud_tick_o |=> !baud_tick_o); // R3
  AST_OFF_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_div == '0) |-> (!sample_tick_o && !baud_tick_o)); // R5
  AST_RESTART_NO_BAUD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_wr |=> !baud_tick_o); // R6
  AST_SAMPLE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sample_tick_o && clk_div >= CDW'(2) && !div_wr) |=> !sample_tick_o); // R8
endmodule

bind ubd_baud_gen ubd_baud_gen_chk #(.CDW(CDW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .clk_div(clk_div), .sample_tick_o(sample_tick_o), .baud_tick_o(baud_tick_o)
);

// File: tb/ubd_baud_gen_test.sv
`timescale 1ns/1ps
module ubd_baud_gen_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        sample_tick_o, baud_tick_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk_i = ~clk_i;

  ubd_baud_gen uut (.*);

  function automatic int eff_bit(input int b);
    return (b < 4) ? 4 : b;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // Observation 1 is the falling edge right after the last write edge.
  task automatic observe(input int div, input int nb, input bit inject, input string req);
    int per, limit, first_s, first_b, second_b, s_between, s_prev, s_gap, dbl;
    bit prev_b;
    per = div * (nb + 1);
    limit = 2 * per + 4;
    first_s = 0; first_b = 0; second_b = 0; s_between = 0;
    s_prev = 0; s_gap = 0; dbl = 0; prev_b = 0;
    for (int i = 1; i <= limit; i++) begin
      if (sample_tick_o) begin
        if (first_s == 0) first_s = i;
        else if (s_gap == 0) s_gap = i - s_prev;
        s_prev = i;
        if (first_b != 0 && second_b == 0) s_between++;
      end
      if (baud_tick_o) begin
        if (prev_b) dbl++;
        if (first_b == 0) first_b = i;
        else if (second_b == 0) second_b = i;
      end
      prev_b = baud_tick_o;
      if (inject && i == 3) begin
        wr_en_i = 1'b1; wr_addr_i = 8'h1C; wr_data_i = 16'h0001;
      end
      if (inject && i == 4) wr_en_i = 1'b0;
      @(negedge clk_i);
    end
    check({req, "/R6 first sample"}, first_s, div);
    check({req, "/R6 first baud"}, first_b, per);
    check({req, "/R3 baud period"}, second_b - first_b, per);
    check({req, "/R2 sample period"}, s_gap, div);
    check({req, "/R3 samples per bit"}, s_between, nb + 1);
    check({req, "/R3 baud one wide"}, dbl, 0);
  endtask

  task automatic run_pair(input int div, input int bd, input int hi, input string req);
    wr(8'h18, 16'(div));
    wr(8'h34, {8'(hi), 8'(bd)});
    observe(div, eff_bit(bd), 1'b0, req);
  endtask

  initial begin
    int cnt;
    // R1 reset state
    #1;
    check("R1 reset sample", int'(sample_tick_o), 0);
    check("R1 reset baud", int'(baud_tick_o), 0);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    cnt = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk_i);
      cnt += int'(sample_tick_o) + int'(baud_tick_o);
    end
    check("R1 R5 no ticks after reset", cnt, 0);

    // R1: reset bit divisor 15 -> 16 samples per bit
    wr(8'h18, 16'd2);
    observe(2, 15, 1'b0, "R1 reset bit divisor");

    // directed corners
    run_pair(1, 4, 0, "R2 R8 div1");
    run_pair(3, 0, 0, "R4 bitdiv0");
    run_pair(2, 3, 0, "R4 bitdiv3");
    run_pair(5, 255, 8'hA5, "R7 upper bits ignored");

    // R7: foreign write mid period leaves phase intact
    wr(8'h18, 16'd7);
    wr(8'h34, 16'd4);
    observe(7, 4, 1'b1, "R7 foreign write");

    // R5 divisor zero stops ticks
    wr(8'h18, 16'd0);
    cnt = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk_i);
      cnt += int'(sample_tick_o) + int'(baud_tick_o);
    end
    check("R5 div zero silent", cnt, 0);

    // random pairs, fixed seed
    void'($urandom(32'h5eed_0017));
    for (int k = 0; k < 10; k++) begin
      int d, b, h;
      d = 1 + int'($urandom % 40);
      b = int'($urandom % 48);
      h = int'($urandom % 256);
      run_pair(d, b, h, "R2 R3 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule